// File: doc/BRIEF.md
# Periodic Tick Interrupt Controller

This block is a byte-wide interrupt flag and enable register pair, in the style of a classic versatile interface adapter, with two periodic interrupt sources built in. A vertical-blank tick fires every `VBL_CYC` clock cycles and a one-second tick fires every `SEC_CYC` cycles. Both are counted on a free-running time base that starts at reset, so every tick falls on an integer multiple of its period. External request lines drive their own flag bits, and a single level IRQ output is raised while any enabled flag is pending.

The register window holds sixteen slots. The slot is chosen by address bits 12:9, so the slots sit 0x200 bytes apart, and every access moves one byte. Besides the flag and enable registers, the window holds an 8-bit output port with its direction register. Writing this port can request power-off: the request fires when the shutdown bit is configured as an output and is written low. Software learns of an interrupt from the IRQ line or from bit 7 of the flag register. It writes ones to the flag register to acknowledge flags, and it uses set/clear writes to the enable register to mask sources.

Top module: `tick_irq_ctrl`

## Requirements
- R1: The vertical-blank flag (flag bit 6) is set by the clock edge whose count since reset release is a multiple of `VBL_CYC`, and at no other edge.
- R2: The one-second flag (flag bit 5) is set by the clock edge whose count since reset release is a multiple of `SEC_CYC`.
- R3: A tick sets its flag bit whether or not the matching enable bit is set. The enable register gates only the IRQ output.
- R4: External request line i (i below `NUM_EXT`, at most 5) drives flag bit i. A low-to-high change sets the bit and a high-to-low change clears it. A change wins over a write in the same cycle. While the line holds its level, the bit can be acknowledged.
- R5: A write to the flag register (slot 0xD) clears each flag whose data bit is 1 and leaves the others unchanged. A tick or a rising request that arrives in the same cycle keeps its bit set.
- R6: A write to the enable register (slot 0xE) with data bit 7 = 1 sets the enable bits chosen by data bits 6:0, and with bit 7 = 0 it clears them. A read of slot 0xE returns the enable bits with bit 7 read as 1.
- R7: Bit 7 of a flag register read is 1 exactly when some flag bit 6:0 is set together with its enable bit, and `irq` carries that same value at all times.
- R8: The slot is taken only from address bits 12:9, so bits 8:0 have no effect. A read of any slot other than 0x0, 0x2, 0xD or 0xE returns 0x00, and a write to such a slot changes no register.
- R9: Slot 0x0 is the port latch and slot 0x2 is its direction register (1 = output). A read of slot 0x0 returns the latch on output bits and `portb_pins` on input bits. `portb_drive` and `portb_oe` show the latch and the direction register.
- R10: A write to slot 0x0 raises `pwr_off_req` for one cycle, one cycle after the write, when direction bit 2 is 1 and data bit 2 is 0. No other write raises it.
- R11: Read data appears with `bus_rvalid` one cycle after the accepted read. After reset, every register is 0, `irq` is low and no pulse is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one byte per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; slot taken from bits 12:9 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| ext_req | input | NUM_EXT | External interrupt request levels |
| portb_pins | input | 8 | Port pin levels read on input bits |
| portb_drive | output | 8 | Port output latch |
| portb_oe | output | 8 | Port direction (1 = output) |
| pwr_off_req | output | 1 | One-cycle power-off request |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with `VBL_CYC` = 40 and `SEC_CYC` = 250, with five request lines and the 13-bit address. At these periods both tick sources fire many times within a few thousand cycles. A flag acknowledge can then be placed exactly on a tick edge, and both ticks arrive together at cycle 1000. The same short periods let the bench watch the vertical-blank flag latch while its enable is off, and then raise `irq` once the enable is set.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

  localparam int unsigned SLOT_W   = 4;
  localparam int unsigned FLAG_W   = 7;

  localparam logic [SLOT_W-1:0] SLOT_PORT = 4'h0;
  localparam logic [SLOT_W-1:0] SLOT_PDIR = 4'h2;
  localparam logic [SLOT_W-1:0] SLOT_FLAG = 4'hD;
  localparam logic [SLOT_W-1:0] SLOT_ENAB = 4'hE;

  localparam int unsigned BIT_SEC  = 5;
  localparam int unsigned BIT_VBL  = 6;
  localparam int unsigned MAX_EXT  = 5;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic [SLOT_W-1:0] slot;
    logic [7:0]        data;
  } bus_req_t;

  // Set/clear write to a mask register: bit 7 picks the direction.
  function automatic logic [FLAG_W-1:0] mask_update(
    input logic [FLAG_W-1:0] cur, input logic [7:0] wd);
    if (wd[7]) return cur | wd[FLAG_W-1:0];
    else       return cur & ~wd[FLAG_W-1:0];
  endfunction

  // Any flag pending together with its enable.
  function automatic logic pending_any(
    input logic [FLAG_W-1:0] flg, input logic [FLAG_W-1:0] ena);
    return |(flg & ena);
  endfunction

  // Output bits return the latch, input bits return the pins.
  function automatic logic [7:0] port_readback(
    input logic [7:0] latch, input logic [7:0] dir, input logic [7:0] pins);
    return (latch & dir) | (pins & ~dir);
  endfunction

  function automatic logic slot_mapped(input logic [SLOT_W-1:0] s);
    return (s == SLOT_PORT) || (s == SLOT_PDIR) ||
           (s == SLOT_FLAG) || (s == SLOT_ENAB);
  endfunction

endpackage

// File: rtl/tip_tick_gen.sv
module tip_tick_gen #(
  parameter int unsigned PERIOD = 1663000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R1 R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R1 R2
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/tip_ext_edges.sv
module tip_ext_edges #(
  parameter int unsigned NUM_EXT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] req,
  output logic [NUM_EXT-1:0] rise,
  output logic [NUM_EXT-1:0] fall
);
  logic [NUM_EXT-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= req;
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_edge
    assign rise[i] =  req[i] & ~prev_q[i];
    assign fall[i] = ~req[i] &  prev_q[i];
  end

endmodule

// File: rtl/tip_flag_bank.sv
module tip_flag_bank
  import tick_irq_pkg::*;
#(
  parameter int unsigned NUM_EXT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_rise,
  input  logic [NUM_EXT-1:0] ext_fall,
  input  logic               vbl_tick,
  input  logic               sec_tick,
  input  logic               flag_wr,
  input  logic               enab_wr,
  input  logic [7:0]         wdata,
  output logic [FLAG_W-1:0]  flags,
  output logic [FLAG_W-1:0]  enab,
  output logic               irq
);
  logic [FLAG_W-1:0] set_vec, drop_vec, ack_vec, flags_d;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_src
    if (b < NUM_EXT && b < BIT_SEC) begin : g_ext
      assign set_vec[b]  = ext_rise[b];
      assign drop_vec[b] = ext_fall[b];
    end else if (b == BIT_SEC) begin : g_sec
      assign set_vec[b]  = sec_tick;
      assign drop_vec[b] = 1'b0;
    end else if (b == BIT_VBL) begin : g_vbl
      assign set_vec[b]  = vbl_tick;
      assign drop_vec[b] = 1'b0;
    end else begin : g_none
      assign set_vec[b]  = 1'b0;
      assign drop_vec[b] = 1'b0;
    end
  end

  assign ack_vec = flag_wr ? wdata[FLAG_W-1:0] : '0;
  assign flags_d = (flags & ~ack_vec & ~drop_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      enab  <= '0;
    end else begin
      flags <= flags_d;
      if (enab_wr) enab <= mask_update(enab, wdata);
    end
  end

  assign irq = pending_any(flags, enab);

  // R3
  vbl_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_tick |=> flags[BIT_VBL]);

  // R3
  sec_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> flags[BIT_SEC]);

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && wdata[BIT_VBL] && !vbl_tick) |=> !flags[BIT_VBL]);

  // R6
  enab_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_wr && wdata[7]) |=> ((enab & $past(wdata[FLAG_W-1:0])) == $past(wdata[FLAG_W-1:0])));

  // R6
  enab_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_wr && !wdata[7]) |=> ((enab & $past(wdata[FLAG_W-1:0])) == '0));

  for (genvar i = 0; i < NUM_EXT && i < BIT_SEC; i++) begin : g_ext_chk
    // R4
    ext_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise[i] |=> flags[i]);
    // R4
    ext_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_fall[i] |=> !flags[i]);
  end

endmodule

// File: rtl/tip_port_ctrl.sv
module tip_port_ctrl
  import tick_irq_pkg::*;
#(
  parameter int unsigned PWR_BIT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_wr,
  input  logic       pdir_wr,
  input  logic [7:0] wdata,
  input  logic [7:0] pins,
  output logic [7:0] latch,
  output logic [7:0] dir,
  output logic [7:0] readback,
  output logic       pwr_off
);
  logic shutdown_ev;

  assign shutdown_ev = port_wr & dir[PWR_BIT] & ~wdata[PWR_BIT];
  assign readback    = port_readback(latch, dir, pins);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch   <= '0;
      dir     <= '0;
      pwr_off <= 1'b0;
    end else begin
      if (port_wr) latch <= wdata;
      if (pdir_wr) dir   <= wdata;
      pwr_off <= shutdown_ev;
    end
  end

  // R10
  pwr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_off) |-> ($past(port_wr) && !latch[PWR_BIT] && dir[PWR_BIT]));

  // R10
  pwr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_off && !$past(shutdown_ev)) |-> 1'b0);

endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
  import tick_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned SLOT_LSB = 9,
  parameter int unsigned NUM_EXT = 5,
  parameter int unsigned VBL_CYC = 1663000,
  parameter int unsigned SEC_CYC = 100000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_EXT-1:0] ext_req,
  input  logic [7:0]         portb_pins,
  output logic [7:0]         portb_drive,
  output logic [7:0]         portb_oe,
  output logic               pwr_off_req,
  output logic               irq
);
  bus_req_t          req;
  logic              vbl_tick, sec_tick;
  logic [NUM_EXT-1:0] ext_rise, ext_fall;
  logic [FLAG_W-1:0] flags, enab;
  logic [7:0]        port_rb, rd_mux;
  logic              rd_flag_ev, rd_void_ev;

  assign req.rd   = bus_sel & ~bus_we;
  assign req.wr   = bus_sel &  bus_we;
  assign req.slot = SLOT_W'(bus_addr >> SLOT_LSB);
  assign req.data = bus_wdata;

  assign rd_flag_ev = req.rd & (req.slot == SLOT_FLAG);
  assign rd_void_ev = req.rd & ~slot_mapped(req.slot);

  tip_tick_gen #(.PERIOD(VBL_CYC)) u_vbl_gen (
    .clk(clk), .rst_n(rst_n), .tick(vbl_tick));

  tip_tick_gen #(.PERIOD(SEC_CYC)) u_sec_gen (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick));

  tip_ext_edges #(.NUM_EXT(NUM_EXT)) u_edges (
    .clk(clk), .rst_n(rst_n), .req(ext_req), .rise(ext_rise), .fall(ext_fall));

  tip_flag_bank #(.NUM_EXT(NUM_EXT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_rise (ext_rise),
    .ext_fall (ext_fall),
    .vbl_tick (vbl_tick),
    .sec_tick (sec_tick),
    .flag_wr  (req.wr && req.slot == SLOT_FLAG),
    .enab_wr  (req.wr && req.slot == SLOT_ENAB),
    .wdata    (req.data),
    .flags    (flags),
    .enab     (enab),
    .irq      (irq)
  );

  tip_port_ctrl #(.PWR_BIT(2)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_wr  (req.wr && req.slot == SLOT_PORT),
    .pdir_wr  (req.wr && req.slot == SLOT_PDIR),
    .wdata    (req.data),
    .pins     (portb_pins),
    .latch    (portb_drive),
    .dir      (portb_oe),
    .readback (port_rb),
    .pwr_off  (pwr_off_req)
  );

  always_comb begin
    case (req.slot)
      SLOT_PORT: rd_mux = port_rb;
      SLOT_PDIR: rd_mux = portb_oe;
      SLOT_FLAG: rd_mux = {irq, flags};
      SLOT_ENAB: rd_mux = {1'b1, enab};
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= req.rd;
      bus_rdata  <= req.rd ? rd_mux : 8'h00;
    end
  end

  // R7
  sum_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(rd_flag_ev)) |-> (bus_rdata[7] == $past(irq)));

  // R8
  void_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(rd_void_ev)) |-> (bus_rdata == 8'h00));

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req.rd |=> bus_rvalid);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (($past(flags) != flags) || ($past(enab) != enab)));

endmodule

// File: tb/test_tick_irq_ctrl.sv
module test_tick_irq_ctrl;
  localparam int VBL = 40;
  localparam int SEC = 250;
  localparam int NEXT = 5;
  localparam int AW = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic            bus_rvalid;
  logic [NEXT-1:0] ext_req = '0;
  logic [7:0]      portb_pins = '0;
  logic [7:0]      portb_drive, portb_oe;
  logic            pwr_off_req, irq;

  tick_irq_ctrl #(.ADDR_W(AW), .NUM_EXT(NEXT), .VBL_CYC(VBL), .SEC_CYC(SEC)) i_tick_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ext_req(ext_req), .portb_pins(portb_pins),
    .portb_drive(portb_drive), .portb_oe(portb_oe),
    .pwr_off_req(pwr_off_req), .irq(irq));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_tag = "R11";

  // reference state built from the requirements
  logic [6:0]      m_flags = '0, m_en = '0, nf;
  logic [7:0]      m_pb = '0, m_dir = '0, m_exp;
  logic [NEXT-1:0] m_prev = '0;
  logic [3:0]      m_slot;
  logic [7:0]      exp_q[$];
  string           tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // driver-side model: pushes expected read data, tracks register state
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_flags = '0; m_en = '0; m_pb = '0; m_dir = '0; m_prev = '0;
    end else begin
      cyc++;
      m_slot = bus_addr[12:9];
      if (bus_sel && !bus_we) begin
        case (m_slot)
          4'h0:    m_exp = (m_pb & m_dir) | (portb_pins & ~m_dir);
          4'h2:    m_exp = m_dir;
          4'hD:    m_exp = {|(m_flags & m_en), m_flags};
          4'hE:    m_exp = {1'b1, m_en};
          default: m_exp = 8'h00;
        endcase
        exp_q.push_back(m_exp);
        tag_q.push_back(cur_tag);
      end
      nf = m_flags;
      if (bus_sel && bus_we && m_slot == 4'hD) nf = nf & ~bus_wdata[6:0];
      for (int i = 0; i < NEXT; i++) begin
        if (ext_req[i] && !m_prev[i]) nf[i] = 1'b1;
        if (!ext_req[i] && m_prev[i]) nf[i] = 1'b0;
      end
      if (cyc % SEC == 0) nf[5] = 1'b1;
      if (cyc % VBL == 0) nf[6] = 1'b1;
      if (bus_sel && bus_we && m_slot == 4'hE)
        m_en = bus_wdata[7] ? (m_en | bus_wdata[6:0]) : (m_en & ~bus_wdata[6:0]);
      if (bus_sel && bus_we && m_slot == 4'h0) m_pb = bus_wdata;
      if (bus_sel && bus_we && m_slot == 4'h2) m_dir = bus_wdata;
      m_prev = ext_req;
      m_flags = nf;
    end
  end

  // monitor: pops and compares read results, watches irq every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_rvalid) begin
        if (exp_q.size() == 0) check(1'b0, "R11 unexpected rvalid", bus_rdata, 8'h00);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(bus_rdata == e, t, bus_rdata, e);
        end
      end
      check(irq == |(m_flags & m_en), "R7 irq", {7'd0, irq}, {7'd0, |(m_flags & m_en)});
    end
  end

  // tasks are entered at a falling edge and return at the next one
  task automatic wr(input logic [3:0] slot, input logic [7:0] d, input logic [8:0] low = 9'h000);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {slot, low}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] slot, input string tag, input logic [8:0] low = 9'h000);
    cur_tag = tag;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {slot, low};
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align(input int p, input int r);
    while (cyc % p != r) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(irq == 1'b0 && bus_rvalid == 1'b0, "R11 reset outputs", {6'd0, irq, bus_rvalid}, 8'h00);
    check(portb_oe == 8'h00 && portb_drive == 8'h00, "R11 reset port", portb_oe, 8'h00);
    check(pwr_off_req == 1'b0, "R11 reset pwr", {7'd0, pwr_off_req}, 8'h00);
    rd(4'hD, "R11 flag reset");
    rd(4'hE, "R6 enable reset reads bit7");
    rd(4'h0, "R11 port reset");

    // R6 set and clear writes to the enable register
    wr(4'hE, 8'h83);
    wr(4'hE, 8'h01);
    rd(4'hE, "R6 set/clear");

    // R4 request line 1 (enabled) and R7 summary
    ext_req[1] = 1'b1; idle(2);
    rd(4'hD, "R4 rise sets");
    check(irq == 1'b1, "R7 irq from request", {7'd0, irq}, 8'h01);
    wr(4'hD, 8'h02);
    rd(4'hD, "R5 ack while held");
    ext_req[1] = 1'b0; idle(2);
    rd(4'hD, "R4 fall after ack");
    // R4 line 0 not enabled: flag set, summary clear
    ext_req[0] = 1'b1; idle(2);
    rd(4'hD, "R7 unenabled flag");
    // R4 change in same cycle as ack: change wins
    ext_req[3] = 1'b1;
    wr(4'hD, 8'h08);
    rd(4'hD, "R4 rise beats ack");
    ext_req[0] = 1'b0; ext_req[3] = 1'b0; idle(2);
    rd(4'hD, "R4 fall clears");
    wr(4'hD, 8'h7F);

    // R1 R3 vertical-blank tick latches with enable off
    align(VBL, 5);
    rd(4'hD, "R1 R3 vbl latched");
    wr(4'hD, 8'h40);
    rd(4'hD, "R5 ack vbl");
    align(VBL, VBL - 1);
    wr(4'hD, 8'h40);
    rd(4'hD, "R5 tick beats ack");
    wr(4'hD, 8'h00);
    rd(4'hD, "R5 zero write keeps");
    wr(4'hD, 8'h40);

    // R2 one-second tick
    align(SEC, 2);
    rd(4'hD, "R2 sec latched");
    wr(4'hD, 8'h7F);

    // R3 enabling the tick drives irq
    wr(4'hE, 8'hC0);
    align(VBL, 1);
    check(irq == 1'b1, "R3 irq after enabled tick", {7'd0, irq}, 8'h01);
    rd(4'hD, "R7 summary with tick");
    wr(4'hE, 8'h40);
    wr(4'hD, 8'h7F);
    rd(4'hE, "R6 clear write");

    // R8 decode on bits 12:9 only, unmapped slots
    wr(4'hE, 8'h84, 9'h1FF);
    rd(4'hE, "R8 low bits ignored", 9'h0A5);
    wr(4'h5, 8'hFF);
    wr(4'hC, 8'hFF);
    rd(4'h5, "R8 unmapped reads 0");
    rd(4'hE, "R8 unmapped write no effect");
    rd(4'hD, "R8 unmapped write flags");

    // R9 port latch and direction
    wr(4'h2, 8'h0F);
    portb_pins = 8'h3C;
    wr(4'h0, 8'hA5);
    check(pwr_off_req == 1'b0, "R10 bit2 high no pulse", {7'd0, pwr_off_req}, 8'h00);
    check(portb_drive == 8'hA5, "R9 drive", portb_drive, 8'hA5);
    check(portb_oe == 8'h0F, "R9 oe", portb_oe, 8'h0F);
    rd(4'h0, "R9 mixed readback");
    rd(4'h2, "R9 direction read");

    // R10 power-off request
    wr(4'h0, 8'hA1);
    check(pwr_off_req == 1'b1, "R10 pulse", {7'd0, pwr_off_req}, 8'h01);
    @(negedge clk);
    check(pwr_off_req == 1'b0, "R10 one cycle", {7'd0, pwr_off_req}, 8'h00);
    wr(4'h2, 8'h0B);
    wr(4'h0, 8'h00);
    check(pwr_off_req == 1'b0, "R10 input bit no pulse", {7'd0, pwr_off_req}, 8'h00);
    wr(4'h2, 8'h04);
    wr(4'hD, 8'h00);
    check(pwr_off_req == 1'b0, "R10 other slot no pulse", {7'd0, pwr_off_req}, 8'h00);

    // R1 R2 coincident ticks at cycle 1000
    wr(4'hD, 8'h7F);
    while (cyc < 1000) @(negedge clk);
    rd(4'hD, "R1 R2 coincident ticks");

    idle(3);
    check(exp_q.size() == 0, "R11 all reads returned", 8'(exp_q.size()), 8'h00);
    finish_run();
  end

endmodule